// File: doc/BRIEF.md
# Register Write Sequencer Engine

This block runs a stored list of register-field writes by itself once the host starts it. The host fills a 32-entry sequence memory through a small set of programming registers. Each entry names a target control register, a bit field inside it (lowest bit and width), the value for that field, a delay code and a last-step flag. The host then writes a start index together with a launch bit. From that entry onward, the engine reads the target register, merges the field into it under a mask, and writes the result back. It waits the programmed delay and then moves to the next entry.

The sequence ends after a step flagged as last has been executed, or after entry 31. At that point the engine drops busy and sets a sticky interrupt flag. The host can stop a running sequence at any time in three ways: the abort bit, clearing the enable bit, or the software reset register. None of them raises the interrupt. While the engine runs, ordinary control registers are closed to the host. The sequencer's own registers and the software reset register stay open.

The host port is a single-cycle write strobe with a combinational read. A write takes effect at the next rising clock edge. Read data follows `host_addr` within the same cycle.

Top module: `field_write_sequencer`

## Requirements
- R1: The enable bit is bit 8 of address 0x6C and resets to 0. A launch is ignored while it is 0. Writing it to 0 while a sequence runs drops busy on the next cycle and does not raise the interrupt flag.
- R2: Address 0x6D holds the start index in bits [4:0], and reads back what was written. A write with bit 8 set and enable on launches at the index carried in that same write, and busy is high from the next cycle.
- R3: An entry is selected through 0x70 bits [4:0] and filled through three words. 0x71 holds target address [7:0], field lowest bit [11:8] and width minus one [15:12]. 0x72 holds the 16-bit field value. 0x73 holds the delay code [3:0] and the last-step flag [4]. Each word reads back from the selected entry.
- R4: A step writes (old & ~mask) | ((value << lowbit) & mask). The mask has width-minus-one plus one ones starting at lowbit, cut off above bit 15. Only targets 0x01..0x3F are written, so an entry aimed at the sequencer's own registers changes nothing.
- R5: A step without delay keeps the engine busy for 3 cycles. A delay code c > 0 adds 2^c cycles after the write.
- R6: After a step, the index advances by one unless that step had the last-step flag set. A sequence that reaches entry 31 without a flag ends after it.
- R7: Writing 1 to bit 9 of 0x6F stops the sequence: busy is low on the next cycle, no later step writes, and the interrupt flag stays clear.
- R8: Busy is on the `seq_busy` port and in bit 0 of 0x6E. Bits [12:8] of 0x6E show the index of the step in progress, and keep the last executed index after the sequence ends.
- R9: While busy, host writes to 0x01..0x3F are dropped and host reads of them return 0. Registers 0x6C-0x73, 0x7F and 0x00 are still serviced.
- R10: A sequence that ends normally sets bit 0 of 0x7F, which drives `irq`. The host clears it by writing 1, and a new end in the same cycle wins over the clear.
- R11: Any write to 0x00 clears all ordinary control registers to 0 and stops a running sequence without raising the interrupt flag.
- R12: After reset the following are all 0: busy, `irq`, enable, status, and the ordinary registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| seq_busy | output | 1 | High while a sequence runs |
| irq | output | 1 | Sticky end-of-sequence interrupt flag |

## Verification
The bench builds the block with its default 32-entry memory and 64-register bank. With these sizes it can launch at index 30 and reach the run-past-the-end stop at entry 31 in a few cycles. It also puts target registers of both the ordinary range and the sequencer's own range into entries. Delay codes up to 10 stay well inside the cycle budget, so the field-merge table checks exact busy lengths with delays. A 1024-cycle wait leaves room to probe the blocked-access, abort, enable-clear and software-reset paths in the middle of a step.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int DATA_W  = 16;
  localparam int TADDR_W = 8;
  localparam int POS_W   = $clog2(DATA_W);
  localparam int DLY_W   = 4;
  localparam int CNT_W   = 1 << DLY_W;

  localparam logic [TADDR_W-1:0] A_SRST   = 8'h00;
  localparam logic [TADDR_W-1:0] A_ENA    = 8'h6C;
  localparam logic [TADDR_W-1:0] A_LAUNCH = 8'h6D;
  localparam logic [TADDR_W-1:0] A_STAT   = 8'h6E;
  localparam logic [TADDR_W-1:0] A_ABORT  = 8'h6F;
  localparam logic [TADDR_W-1:0] A_ESEL   = 8'h70;
  localparam logic [TADDR_W-1:0] A_EW0    = 8'h71;
  localparam logic [TADDR_W-1:0] A_EW1    = 8'h72;
  localparam logic [TADDR_W-1:0] A_EW2    = 8'h73;
  localparam logic [TADDR_W-1:0] A_IRQ    = 8'h7F;

  typedef struct packed {
    logic [TADDR_W-1:0] tgt;
    logic [POS_W-1:0]   lsb;
    logic [POS_W-1:0]   wm1;
    logic [DATA_W-1:0]  val;
    logic [DLY_W-1:0]   dly;
    logic               last;
  } seq_entry_t;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_MERGE, S_WRITE, S_WAIT} seq_state_e;

  function automatic logic [DATA_W-1:0] field_mask(input logic [POS_W-1:0] lsb,
                                                   input logic [POS_W-1:0] wm1);
    return DATA_W'(((32'd1 << (int'(wm1) + 1)) - 32'd1) << lsb);
  endfunction

  function automatic logic [DATA_W-1:0] field_merge(input logic [DATA_W-1:0] old,
                                                    input logic [DATA_W-1:0] val,
                                                    input logic [POS_W-1:0] lsb,
                                                    input logic [POS_W-1:0] wm1);
    logic [DATA_W-1:0] m;
    m = field_mask(lsb, wm1);
    return (old & ~m) | ((val << lsb) & m);
  endfunction

  function automatic logic [CNT_W-1:0] delay_cycles(input logic [DLY_W-1:0] code);
    return (code == '0) ? '0 : CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/wseq_seq_mem.sv
module wseq_seq_mem
  import wseq_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [1:0]        wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  run_idx_i,
  output seq_entry_t        run_ent_o,
  input  logic [IDX_W-1:0]  host_idx_i,
  output seq_entry_t        host_ent_o
);
  seq_entry_t ent_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(e)) begin
        case (wr_word_i)
          2'd0: begin
            ent_q[e].tgt <= wr_data_i[7:0];
            ent_q[e].lsb <= wr_data_i[11:8];
            ent_q[e].wm1 <= wr_data_i[15:12];
          end
          2'd1: ent_q[e].val <= wr_data_i;
          default: begin
            ent_q[e].dly  <= wr_data_i[3:0];
            ent_q[e].last <= wr_data_i[4];
          end
        endcase
      end
    end
  end

  assign run_ent_o  = ent_q[run_idx_i];
  assign host_ent_o = ent_q[host_idx_i];
endmodule

// File: rtl/wseq_ctrl_bank.sv
module wseq_ctrl_bank
  import wseq_pkg::*;
#(
  parameter int REGS = 64,
  parameter int LW   = $clog2(REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               host_we_i,
  input  logic [TADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  input  logic               seq_we_i,
  input  logic [TADDR_W-1:0] seq_addr_i,
  input  logic [DATA_W-1:0]  seq_wdata_i,
  output logic [DATA_W-1:0]  seq_rdata_o
);
  logic [DATA_W-1:0] regs [REGS];

  function automatic logic in_bank(input logic [TADDR_W-1:0] a);
    return (a != '0) && (int'(a) < REGS);
  endfunction

  for (genvar r = 0; r < REGS; r++) begin : g_reg
    if (r == 0) begin : g_hole
      assign regs[r] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         regs[r] <= '0;
        else if (clear_i)                                   regs[r] <= '0;
        else if (seq_we_i && seq_addr_i == TADDR_W'(r))     regs[r] <= seq_wdata_i;
        else if (host_we_i && host_addr_i == TADDR_W'(r))   regs[r] <= host_wdata_i;
      end
    end
  end

  assign host_rdata_o = in_bank(host_addr_i) ? regs[host_addr_i[LW-1:0]] : '0;
  assign seq_rdata_o  = in_bank(seq_addr_i)  ? regs[seq_addr_i[LW-1:0]]  : '0;

  // R9: the host port is closed whenever the engine writes
  assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we_i |-> !host_we_i);
endmodule

// File: rtl/wseq_engine.sv
module wseq_engine
  import wseq_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  input  logic               halt_i,
  input  seq_entry_t         ent_i,
  input  logic [DATA_W-1:0]  bank_rdata_i,
  output logic [IDX_W-1:0]   cur_idx_o,
  output logic               busy_o,
  output logic               bank_we_o,
  output logic [TADDR_W-1:0] bank_addr_o,
  output logic [DATA_W-1:0]  bank_wdata_o,
  output logic               done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] old_q, new_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  dly_len;
  logic              step_over, seq_fin;

  assign dly_len   = delay_cycles(ent_i.dly);
  assign step_over = (state_q == S_WRITE && dly_len == '0) || (state_q == S_WAIT && cnt_q == CNT_W'(1));
  assign seq_fin   = step_over && (ent_i.last || idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      old_q   <= '0;
      new_q   <= '0;
      cnt_q   <= '0;
    end else if (halt_i) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          idx_q   <= start_idx_i;
          state_q <= S_READ;
        end
        S_READ: begin
          old_q   <= bank_rdata_i;
          state_q <= S_MERGE;
        end
        S_MERGE: begin
          new_q   <= field_merge(old_q, ent_i.val, ent_i.lsb, ent_i.wm1);
          state_q <= S_WRITE;
        end
        S_WRITE, S_WAIT: begin
          if (state_q == S_WRITE && dly_len != '0) begin
            cnt_q   <= dly_len;
            state_q <= S_WAIT;
          end else if (state_q == S_WAIT && !step_over) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (seq_fin) begin
            state_q <= S_IDLE;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= S_READ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign cur_idx_o    = idx_q;
  assign bank_we_o    = (state_q == S_WRITE) && !halt_i;
  assign bank_addr_o  = ent_i.tgt;
  assign bank_wdata_o = new_q;
  assign done_o       = seq_fin && !halt_i;

  // R8: busy only falls at a normal end or a halt
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o || halt_i));
  // R6: while running, the index only ever moves up by one
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && idx_q != $past(idx_q)) |-> idx_q == IDX_W'($past(idx_q) + 1'b1));
  // R7: a halt request empties the engine on the next cycle
  assert_halt_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> !busy_o);
  // R5: the delay counter never idles at zero inside a wait
  assert_wait_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) |-> cnt_q != '0);
endmodule

// File: rtl/field_write_sequencer.sv
module field_write_sequencer
  import wseq_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int BANK_REGS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [TADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               seq_busy,
  output logic               irq
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic               ena_q, irq_q;
  logic [IDX_W-1:0]   launch_idx_q, sel_q;
  logic               busy, seq_done, bank_we;
  logic [IDX_W-1:0]   cur_idx;
  logic [TADDR_W-1:0] bank_addr;
  logic [DATA_W-1:0]  bank_wdata, bank_rd_seq, bank_rd_host;
  seq_entry_t         run_ent, host_ent;
  logic               srst_evt, abort_evt, ena_off_evt, start_evt, halt, mem_wr, host_bank_we;

  function automatic logic is_ordinary(input logic [TADDR_W-1:0] a);
    return (a != A_SRST) && (int'(a) < BANK_REGS);
  endfunction

  assign srst_evt     = host_wr && host_addr == A_SRST;
  assign abort_evt    = host_wr && host_addr == A_ABORT && host_wdata[9];
  assign ena_off_evt  = host_wr && host_addr == A_ENA && !host_wdata[8];
  assign halt         = srst_evt || abort_evt || ena_off_evt;
  assign start_evt    = host_wr && host_addr == A_LAUNCH && host_wdata[8] && ena_q && !busy;
  assign mem_wr       = host_wr && (host_addr == A_EW0 || host_addr == A_EW1 || host_addr == A_EW2);
  assign host_bank_we = host_wr && !busy && is_ordinary(host_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q        <= 1'b0;
      irq_q        <= 1'b0;
      launch_idx_q <= '0;
      sel_q        <= '0;
    end else begin
      if (host_wr && host_addr == A_ENA)    ena_q        <= host_wdata[8];
      if (host_wr && host_addr == A_LAUNCH) launch_idx_q <= host_wdata[IDX_W-1:0];
      if (host_wr && host_addr == A_ESEL)   sel_q        <= host_wdata[IDX_W-1:0];
      if (seq_done)                                          irq_q <= 1'b1;
      else if (host_wr && host_addr == A_IRQ && host_wdata[0]) irq_q <= 1'b0;
    end
  end

  wseq_seq_mem #(.ENTRIES(ENTRIES)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(mem_wr), .wr_idx_i(sel_q), .wr_word_i(2'(host_addr - A_EW0)), .wr_data_i(host_wdata),
    .run_idx_i(cur_idx), .run_ent_o(run_ent),
    .host_idx_i(sel_q), .host_ent_o(host_ent)
  );

  wseq_ctrl_bank #(.REGS(BANK_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear_i(srst_evt),
    .host_we_i(host_bank_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(bank_rd_host),
    .seq_we_i(bank_we), .seq_addr_i(bank_addr), .seq_wdata_i(bank_wdata), .seq_rdata_o(bank_rd_seq)
  );

  wseq_engine #(.ENTRIES(ENTRIES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_evt), .start_idx_i(host_wdata[IDX_W-1:0]), .halt_i(halt),
    .ent_i(run_ent), .bank_rdata_i(bank_rd_seq),
    .cur_idx_o(cur_idx), .busy_o(busy),
    .bank_we_o(bank_we), .bank_addr_o(bank_addr), .bank_wdata_o(bank_wdata), .done_o(seq_done)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_ENA:    host_rdata[8] = ena_q;
      A_LAUNCH: host_rdata[IDX_W-1:0] = launch_idx_q;
      A_STAT: begin
        host_rdata[0]         = busy;
        host_rdata[8 +: IDX_W] = cur_idx;
      end
      A_ESEL:   host_rdata[IDX_W-1:0] = sel_q;
      A_EW0:    host_rdata = {host_ent.wm1, host_ent.lsb, host_ent.tgt};
      A_EW1:    host_rdata = host_ent.val;
      A_EW2:    host_rdata[4:0] = {host_ent.last, host_ent.dly};
      A_IRQ:    host_rdata[0] = irq_q;
      default:  if (!busy) host_rdata = bank_rd_host;
    endcase
  end

  assign seq_busy = busy;
  assign irq      = irq_q;

  // R1: with enable off an idle engine stays idle
  assert_no_start_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena_q && !busy) |=> !busy);
  // R10: the flag only rises on a normal end
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(seq_done));
  // R11: a software reset never raises the flag
  assert_srst_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_evt && !irq_q) |=> !irq_q);
endmodule

// File: tb/field_write_sequencer_bench.sv
`timescale 1ns/1ps
module field_write_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        seq_busy, irq;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  field_write_sequencer u_field_write_sequencer (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .seq_busy(seq_busy), .irq(irq)
  );

  // {delay code, lowbit, width-1, value, old register value, expected register value}
  localparam logic [59:0] VEC [6] = '{
    60'h0_0_F_BEEF_1234_BEEF,
    60'h1_4_3_000A_FFFF_FFAF,
    60'h3_C_7_0035_0000_5000,
    60'h0_0_0_0000_00FF_00FE,
    60'h5_8_3_00FF_1234_1F34,
    60'h2_F_0_0001_0000_8000
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic prog(input int idx, input logic [7:0] tgt, input logic [3:0] lsb, input logic [3:0] wm1,
                      input logic [15:0] val, input logic [3:0] dly, input logic last);
    hw(8'h70, 16'(idx));
    hw(8'h71, {wm1, lsb, tgt});
    hw(8'h72, val);
    hw(8'h73, {11'b0, last, dly});
  endtask

  task automatic launch_count(input int idx, output int n);
    hw(8'h6D, 16'h0100 | 16'(idx));
    n = 0;
    while (seq_busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk(!seq_busy && !irq, "R12 busy/irq", {seq_busy, irq}, 0);
    hr(8'h6C, d); chk(d == 0, "R12 enable", d, 0);
    hr(8'h6E, d); chk(d == 0, "R12 status", d, 0);
    hr(8'h05, d); chk(d == 0, "R12 bank", d, 0);

    // R1 launch ignored while disabled
    prog(0, 8'h05, 4'd0, 4'd15, 16'h1111, 4'd0, 1'b1);
    hw(8'h6D, 16'h0100);
    @(negedge clk);
    chk(!seq_busy, "R1 start while disabled", seq_busy, 0);
    hr(8'h05, d); chk(d == 0, "R1 no write while disabled", d, 0);
    hw(8'h6C, 16'h0100);
    hr(8'h6C, d); chk(d == 16'h0100, "R1 enable readback", d, 16'h0100);

    // R4 R5 field merge table
    for (int i = 0; i < 6; i++) begin
      logic [3:0] dly, lsb, wm1;
      logic [15:0] val, old, exp;
      int exp_n;
      {dly, lsb, wm1, val, old, exp} = VEC[i];
      exp_n = 3 + ((dly == 0) ? 0 : (1 << dly));
      hw(8'h05, old);
      prog(i, 8'h05, lsb, wm1, val, dly, 1'b1);
      launch_count(i, n);
      hr(8'h05, d); chk(d == exp, $sformatf("R4 merge vec %0d", i), d, exp);
      chk(n == exp_n, $sformatf("R5 busy length vec %0d", i), n, exp_n);
      chk(irq, "R10 irq at end", irq, 1);
      hr(8'h6E, d); chk(d == (16'(i) << 8), "R8 index after end", d, 16'(i) << 8);
      hw(8'h7F, 16'h0001);
      chk(!irq, "R10 irq cleared", irq, 0);
    end
    hr(8'h6D, d); chk(d == 5, "R2 start index readback", d, 5);

    // R3 entry readback
    prog(20, 8'h0A, 4'd0, 4'd15, 16'h1111, 4'd0, 1'b0);
    hr(8'h71, d); chk(d == 16'hF00A, "R3 word0", d, 16'hF00A);
    hr(8'h72, d); chk(d == 16'h1111, "R3 word1", d, 16'h1111);
    hr(8'h73, d); chk(d == 16'h0000, "R3 word2", d, 0);

    // R6 chained steps stop at the flagged one
    prog(21, 8'h0B, 4'd0, 4'd15, 16'h2222, 4'd0, 1'b0);
    prog(22, 8'h0C, 4'd0, 4'd15, 16'h3333, 4'd0, 1'b1);
    prog(23, 8'h0D, 4'd0, 4'd15, 16'h4444, 4'd0, 1'b1);
    launch_count(20, n);
    chk(n == 9, "R6 three-step length", n, 9);
    hr(8'h0A, d); chk(d == 16'h1111, "R6 step 20", d, 16'h1111);
    hr(8'h0C, d); chk(d == 16'h3333, "R6 step 22", d, 16'h3333);
    hr(8'h0D, d); chk(d == 0, "R6 stops at last flag", d, 0);
    hr(8'h6E, d); chk(d == 16'h1600, "R8 last executed index", d, 16'h1600);
    hw(8'h7F, 16'h0001);

    // R4 target outside the bank is not written
    prog(24, 8'h6C, 4'd8, 4'd0, 16'h0000, 4'd0, 1'b1);
    launch_count(24, n);
    hr(8'h6C, d); chk(d == 16'h0100, "R4 own register untouched", d, 16'h0100);
    hw(8'h7F, 16'h0001);

    // R6 run past the last entry
    prog(30, 8'h0E, 4'd0, 4'd15, 16'hAAAA, 4'd0, 1'b0);
    prog(31, 8'h0F, 4'd0, 4'd15, 16'h5555, 4'd0, 1'b0);
    launch_count(30, n);
    chk(n == 6, "R6 run-past length", n, 6);
    chk(irq, "R6 run-past irq", irq, 1);
    hr(8'h6E, d); chk(d == 16'h1F00, "R6 run-past index", d, 16'h1F00);
    hr(8'h0F, d); chk(d == 16'h5555, "R6 entry 31 written", d, 16'h5555);
    hw(8'h7F, 16'h0001);

    // R9 R7 blocked access and abort during a long wait
    prog(25, 8'h10, 4'd0, 4'd15, 16'h0F0F, 4'd10, 1'b0);
    prog(26, 8'h11, 4'd0, 4'd15, 16'h7777, 4'd0, 1'b1);
    hw(8'h09, 16'h0009);
    hw(8'h6D, 16'h0119);
    repeat (6) @(negedge clk);
    hw(8'h09, 16'hDEAD);
    hr(8'h05, d); chk(d == 0, "R9 blocked read", d, 0);
    hr(8'h6E, d); chk(d == 16'h1901, "R9 status serviced while busy", d, 16'h1901);
    hw(8'h6F, 16'h0200);
    chk(!seq_busy, "R7 busy low after abort", seq_busy, 0);
    chk(!irq, "R7 no irq on abort", irq, 0);
    hr(8'h10, d); chk(d == 16'h0F0F, "R7 write before abort kept", d, 16'h0F0F);
    hr(8'h11, d); chk(d == 0, "R7 next step not run", d, 0);
    hr(8'h09, d); chk(d == 16'h0009, "R9 blocked write dropped", d, 16'h0009);

    // R1 clearing enable halts
    hw(8'h6D, 16'h0119);
    repeat (6) @(negedge clk);
    hw(8'h6C, 16'h0000);
    chk(!seq_busy && !irq, "R1 enable clear halts", {seq_busy, irq}, 0);
    hw(8'h6D, 16'h0119);
    @(negedge clk);
    chk(!seq_busy, "R1 relaunch ignored when off", seq_busy, 0);
    hw(8'h6C, 16'h0100);

    // R11 software reset during a run
    hw(8'h6D, 16'h0119);
    repeat (6) @(negedge clk);
    hw(8'h00, 16'h0000);
    chk(!seq_busy && !irq, "R11 reset halts quietly", {seq_busy, irq}, 0);
    hr(8'h10, d); chk(d == 0, "R11 bank cleared", d, 0);
    hr(8'h6C, d); chk(d == 16'h0100, "R11 own register kept", d, 16'h0100);

    finish_run();
  end
endmodule